// File: doc/BRIEF.md
# Mailbox Data Object Exchange Controller

This block gives a host a small register window through which it trades dword-framed data objects with on-chip protocol responders. The host writes a request one dword at a time into a write-mailbox register and then sets a GO bit in a control register. The block checks the request's shape and routes it by vendor ID and object type. It then offers the response one dword per read of a read-mailbox register. A status register shows an error flag and a data-object-ready flag. An abort bit in the control register returns the whole exchange to its idle state.

Two responders are built in. The first is a discovery responder: given an index, it reports which protocols the block serves and the index of the next entry. The second is a table of further protocols, set by parameter, each of which answers with the inverted argument dword. Request storage depth, the register window base and the protocol table are all parameters.

Top module: `dox_mailbox`

## Requirements
- R1: Only accesses with reg_bytes equal to 4 take effect. Any other size leaves all state unchanged on a write, and on a read returns zero without popping the read mailbox.
- R2: The register offsets from CAP_BASE are 0x04 capability, 0x08 control, 0x0C status, 0x10 write mailbox and 0x14 read mailbox. Reads of the capability register, the control register and any unmapped offset return zero. In the status word, bit 2 is error, bit 31 is object-ready, and bits 0 and 1 always read 0.
- R3: The request length is the low 18 bits of the second dword written, counted in dwords. The upper 14 bits are ignored. A length field of zero means 2^18 dwords.
- R4: When the count of accepted request dwords equals the captured length, any further write-mailbox data is dropped silently and the count does not move.
- R5: A GO (control bit 31) whose request count or captured length is not exactly 3 sets the error flag and dispatches nothing.
- R6: A well-formed request is routed by vendor ID (dword0 bits 15:0) and object type (dword0 bits 23:16). If neither the discovery pair (0x0001, 0x00) nor any table entry matches, the error flag is set.
- R7: Every GO, whether it succeeds or fails, returns the request count to zero, so a new object can be written without an abort.
- R8: A successful dispatch sets object-ready and restarts the response read position at dword 0. The error flag is sticky until an abort.
- R9: A discovery request carries an index in dword2 bits 7:0. The answer is header 0x00000001, then length 3, then an entry laid out as {next[31:24], type[23:16], vendor[15:0]}. Index 0 describes discovery itself with next 1. Index k from 1 to N_PROT describes table entry k-1, with next k+1, or next 0 for the last entry. Any larger index returns 0x0000FFFF.
- R10: A request matching a table entry is answered with the entry's type and vendor in the header (bits 31:24 zero), then length 3, then the bitwise inverse of the request's dword2.
- R11: Each full-size read of the read mailbox returns the next response dword. The response length comes from bits 17:0 of response dword1. Object-ready clears after the last dword is read.
- R12: A read of the read mailbox while object-ready is clear returns zero and sets the error flag.
- R13: A control write with bit 0 set clears the request count, the captured length, the response position, the error flag and object-ready. A GO bit in the same write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_bytes | input | 3 | Access size in bytes; only 4 is honoured |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd and held until the next read |

## Verification
The bench goes after the length corner cases. A fourth dword sent after a length-3 header must be dropped. A design that stored it would count 4 and fail the GO. A length-2 header must stop at two dwords, and a length field with its upper 14 bits set must still be read as 3; a design that used the full dword as the length would raise an error on that object. The bench also issues a GO after a failed request without an abort, and a design that skipped the index reset would never accept a request again. Reads are covered in three ways. A half-size read while a response is waiting must return zero and leave the stream in place, so a design that popped on it would return dword1 on the next read. A read of an empty mailbox must raise the error flag. A write with both abort and GO set must leave everything idle. The discovery walk checks the last entry's zero next index and the 0x0000FFFF entry for an index past the end of the table.

// File: rtl/dox_pkg.sv
package dox_pkg;

  localparam int LEN_W  = 18;
  localparam int IDX_W  = LEN_W + 1;
  localparam int RSP_DW = 3;

  localparam int OFS_CAP = 'h04;
  localparam int OFS_CTL = 'h08;
  localparam int OFS_STS = 'h0C;
  localparam int OFS_WMB = 'h10;
  localparam int OFS_RMB = 'h14;

  localparam int CTL_ABORT = 0;
  localparam int CTL_GO    = 31;
  localparam int STS_ERR   = 2;
  localparam int STS_READY = 31;

  localparam logic [15:0] DISC_VID   = 16'h0001;
  localparam logic [7:0]  DISC_TYPE  = 8'h00;
  localparam logic [31:0] NULL_ENTRY = 32'h0000_FFFF;

  typedef enum logic [2:0] {
    REG_NONE, REG_CAP, REG_CTL, REG_STS, REG_WMB, REG_RMB
  } reg_sel_e;

  // dword count held in a header dword; a zero field stands for the maximum
  function automatic logic [IDX_W-1:0] decode_len(input logic [31:0] dw);
    logic [IDX_W-1:0] n;
    n = {1'b0, dw[LEN_W-1:0]};
    if (n == '0) n = IDX_W'(1) << LEN_W;
    return n;
  endfunction

  function automatic logic [31:0] disc_entry(input logic [7:0] nxt,
                                             input logic [23:0] id);
    return {nxt, id};
  endfunction

  function automatic logic [31:0] status_word(input logic err, input logic rdy);
    logic [31:0] s;
    s = '0;
    s[STS_ERR]   = err;
    s[STS_READY] = rdy;
    return s;
  endfunction

endpackage

// File: rtl/dox_reqbuf.sv
module dox_reqbuf
  import dox_pkg::*;
#(
  parameter int BUF_DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [31:0]      wdata,
  input  logic             clr_all,
  input  logic             clr_idx,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] len_q,
  output logic [31:0]      hdr_dw,
  output logic [31:0]      arg_dw,
  output logic             drop_evt
);

  logic [31:0]      slot_q [BUF_DW];
  logic [IDX_W-1:0] len_next;
  logic             accept;

  always_comb begin
    len_next = (idx_q == IDX_W'(1)) ? decode_len(wdata) : len_q;
  end

  assign drop_evt = push && (len_next != '0) && (idx_q == len_next);
  assign accept   = push && !drop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (clr_all) begin
      idx_q <= '0;
      len_q <= '0;
    end else if (clr_idx) begin
      idx_q <= '0;
    end else if (push) begin
      if (idx_q == IDX_W'(1)) len_q <= len_next;
      if (accept) idx_q <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < BUF_DW; s++) slot_q[s] <= '0;
    end else begin
      for (int s = 0; s < BUF_DW; s++)
        if (accept && idx_q == IDX_W'(s)) slot_q[s] <= wdata;
    end
  end

  assign hdr_dw = slot_q[0];
  assign arg_dw = slot_q[2];

  p_drop_holds_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !clr_all && !clr_idx) |=> (idx_q == $past(idx_q)));

  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx_q == IDX_W'(1) && !clr_all && !clr_idx) |=> (len_q != '0));

endmodule

// File: rtl/dox_responder.sv
module dox_responder
  import dox_pkg::*;
#(
  parameter int N_PROT = 2,
  parameter logic [N_PROT-1:0][23:0] PROT_ID = {24'h03_1E98, 24'h02_1E98}
) (
  input  logic [31:0] req_hdr,
  input  logic [31:0] req_arg,
  output logic        hit,
  output logic [31:0] rsp_hdr,
  output logic [31:0] rsp_len,
  output logic [31:0] rsp_arg
);

  logic              is_disc;
  logic [N_PROT-1:0] tbl_hit;
  logic [23:0]       tbl_id;
  logic [31:0]       entry;
  logic [7:0]        want;

  assign is_disc = (req_hdr[15:0] == DISC_VID) && (req_hdr[23:16] == DISC_TYPE);

  for (genvar k = 0; k < N_PROT; k++) begin : g_match
    assign tbl_hit[k] = (req_hdr[23:0] == PROT_ID[k]);
  end

  always_comb begin
    tbl_id = '0;
    for (int k = N_PROT - 1; k >= 0; k--)
      if (tbl_hit[k]) tbl_id = PROT_ID[k];
  end

  assign want = req_arg[7:0];

  always_comb begin
    entry = NULL_ENTRY;
    if (want == 8'd0) entry = disc_entry(8'd1, {DISC_TYPE, DISC_VID});
    for (int k = 0; k < N_PROT; k++)
      if (want == 8'(k + 1))
        entry = disc_entry((k + 1 == N_PROT) ? 8'd0 : 8'(k + 2), PROT_ID[k]);
  end

  assign hit     = is_disc || (|tbl_hit);
  assign rsp_hdr = is_disc ? {8'h00, DISC_TYPE, DISC_VID} : {8'h00, tbl_id};
  assign rsp_len = 32'(RSP_DW);
  assign rsp_arg = is_disc ? entry : ~req_arg;

endmodule

// File: rtl/dox_mailbox.sv
module dox_mailbox
  import dox_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CAP_BASE = 12'h100,
  parameter int BUF_DW = 8,
  parameter int N_PROT = 2,
  parameter logic [N_PROT-1:0][23:0] PROT_ID = {24'h03_1E98, 24'h02_1E98}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [2:0]        reg_bytes,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam int REQ_DW = 3;

  logic [ADDR_W-1:0] ofs;
  reg_sel_e          sel;
  logic              full, wr_hit, rd_hit, ctl_wr;
  logic              abort_evt, go_evt, push_evt, pop_req;
  logic              underflow_evt, pop_evt, last_pop_evt;
  logic              req_ok, dispatch_ok, dispatch_fail, drop_evt;

  logic [IDX_W-1:0]  req_idx, req_len;
  logic [31:0]       req_hdr, req_arg;
  logic              rsp_hit;
  logic [31:0]       nxt_hdr, nxt_len, nxt_arg;

  logic              err_q, ready_q;
  logic [IDX_W-1:0]  rsp_idx_q, rsp_len;
  logic [31:0]       rsp_q [RSP_DW];
  logic [31:0]       pop_data, rd_mux;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] o);
    if (o == ADDR_W'(OFS_CAP)) return REG_CAP;
    if (o == ADDR_W'(OFS_CTL)) return REG_CTL;
    if (o == ADDR_W'(OFS_STS)) return REG_STS;
    if (o == ADDR_W'(OFS_WMB)) return REG_WMB;
    if (o == ADDR_W'(OFS_RMB)) return REG_RMB;
    return REG_NONE;
  endfunction

  assign ofs    = reg_addr - CAP_BASE;
  assign sel    = decode_ofs(ofs);
  assign full   = (reg_bytes == 3'd4);
  assign wr_hit = reg_wr && full;
  assign rd_hit = reg_rd && full;
  assign ctl_wr = wr_hit && (sel == REG_CTL);

  assign abort_evt = ctl_wr && reg_wdata[CTL_ABORT];
  assign go_evt    = ctl_wr && reg_wdata[CTL_GO] && !reg_wdata[CTL_ABORT];
  assign push_evt  = wr_hit && (sel == REG_WMB);
  assign pop_req   = rd_hit && (sel == REG_RMB);

  dox_reqbuf #(.BUF_DW(BUF_DW)) u_reqbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push_evt),
    .wdata   (reg_wdata),
    .clr_all (abort_evt),
    .clr_idx (go_evt),
    .idx_q   (req_idx),
    .len_q   (req_len),
    .hdr_dw  (req_hdr),
    .arg_dw  (req_arg),
    .drop_evt(drop_evt)
  );

  dox_responder #(.N_PROT(N_PROT), .PROT_ID(PROT_ID)) u_resp (
    .req_hdr(req_hdr),
    .req_arg(req_arg),
    .hit    (rsp_hit),
    .rsp_hdr(nxt_hdr),
    .rsp_len(nxt_len),
    .rsp_arg(nxt_arg)
  );

  assign req_ok        = (req_idx == IDX_W'(REQ_DW)) && (req_len == IDX_W'(REQ_DW));
  assign dispatch_ok   = go_evt && req_ok && rsp_hit;
  assign dispatch_fail = go_evt && !(req_ok && rsp_hit);

  assign rsp_len       = decode_len(rsp_q[1]);
  assign underflow_evt = pop_req && !ready_q;
  assign pop_evt       = pop_req && ready_q;
  assign last_pop_evt  = pop_evt && (rsp_idx_q + IDX_W'(1) == rsp_len);

  always_comb begin
    pop_data = '0;
    for (int k = 0; k < RSP_DW; k++)
      if (rsp_idx_q == IDX_W'(k)) pop_data = rsp_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      ready_q   <= 1'b0;
      rsp_idx_q <= '0;
      for (int k = 0; k < RSP_DW; k++) rsp_q[k] <= '0;
    end else if (abort_evt) begin
      err_q     <= 1'b0;
      ready_q   <= 1'b0;
      rsp_idx_q <= '0;
    end else begin
      if (dispatch_fail || underflow_evt) err_q <= 1'b1;
      if (dispatch_ok) begin
        ready_q   <= 1'b1;
        rsp_idx_q <= '0;
        rsp_q[0]  <= nxt_hdr;
        rsp_q[1]  <= nxt_len;
        rsp_q[2]  <= nxt_arg;
      end else if (pop_evt) begin
        rsp_idx_q <= rsp_idx_q + IDX_W'(1);
        if (last_pop_evt) ready_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (full) begin
      unique case (sel)
        REG_STS: rd_mux = status_word(err_q, ready_q);
        REG_RMB: rd_mux = ready_q ? pop_data : 32'h0;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  p_abort_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!ready_q && !err_q && req_idx == '0 && req_len == '0));

  p_underflow_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_evt && !abort_evt) |=> (err_q && reg_rdata == 32'h0));

  p_last_pop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_pop_evt |=> !ready_q);

  p_partial_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !full) |=> (reg_rdata == 32'h0));

  p_partial_read_no_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !full && !reg_wr) |=> $stable(rsp_idx_q));

  p_go_resets_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt |=> (req_idx == '0));

  p_bad_go_no_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_evt && !req_ok && !ready_q) |=> !ready_q);

  p_cap_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && sel == REG_CAP) |=> (reg_rdata == 32'h0));

  p_dispatch_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_ok |=> (ready_q && rsp_idx_q == '0));

endmodule

// File: tb/dox_mailbox_tb.sv
`timescale 1ns/1ps
module dox_mailbox_tb_top;

  localparam logic [11:0] BASE = 12'h100;
  localparam logic [11:0] A_CAP = BASE + 12'h04;
  localparam logic [11:0] A_CTL = BASE + 12'h08;
  localparam logic [11:0] A_STS = BASE + 12'h0C;
  localparam logic [11:0] A_WMB = BASE + 12'h10;
  localparam logic [11:0] A_RMB = BASE + 12'h14;
  localparam logic [31:0] GO    = 32'h8000_0000;
  localparam logic [31:0] ABORT = 32'h0000_0001;
  localparam logic [31:0] ST_RDY = 32'h8000_0000;
  localparam logic [31:0] ST_ERR = 32'h0000_0004;
  localparam logic [31:0] P_A = 32'h0002_1E98;
  localparam logic [31:0] P_B = 32'h0003_1E98;
  localparam logic [31:0] DISC = 32'h0000_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [2:0]  reg_bytes = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dox_mailbox #(
    .ADDR_W(12), .CAP_BASE(12'h100), .BUF_DW(8), .N_PROT(2),
    .PROT_ID({24'h03_1E98, 24'h02_1E98})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_bytes(reg_bytes), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] n = 3'd4);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_bytes = n;
    @(negedge clk);
    reg_wr = 1'b0; reg_bytes = 3'd4;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [2:0] n = 3'd4);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a; reg_bytes = n;
    @(negedge clk);
    reg_rd = 1'b0; reg_bytes = 3'd4;
    d = reg_rdata;
  endtask

  task automatic send3(input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
    wr(A_WMB, d0); wr(A_WMB, d1); wr(A_WMB, d2);
  endtask

  task automatic expect_status(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(A_STS, v);
    check(req, v, exp);
  endtask

  task automatic expect_stream(input string req, input logic [31:0] e0,
                               input logic [31:0] e1, input logic [31:0] e2);
    logic [31:0] v;
    rd(A_RMB, v); check({req, " dw0"}, v, e0);
    rd(A_RMB, v); check({req, " dw1"}, v, e1);
    expect_status({req, " ready before last (R11)"}, ST_RDY);
    rd(A_RMB, v); check({req, " dw2"}, v, e2);
    expect_status({req, " ready cleared after last (R11)"}, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    expect_status("R2 reset status", 32'h0);
    rd(A_CAP, v); check("R2 capability reads zero", v, 32'h0);
    rd(A_CTL, v); check("R2 control reads zero", v, 32'h0);
    rd(BASE + 12'h18, v); check("R2 unmapped reads zero", v, 32'h0);
  endtask

  task automatic t_discovery;
    send3(DISC, 32'd3, 32'd0); wr(A_CTL, GO);
    expect_status("R8 ready after discovery GO", ST_RDY);
    expect_stream("R9 disc idx0", DISC, 32'd3, 32'h0100_0001);
    send3(DISC, 32'd3, 32'd1); wr(A_CTL, GO);
    expect_stream("R9 disc idx1", DISC, 32'd3, 32'h0202_1E98);
    send3(DISC, 32'd3, 32'd2); wr(A_CTL, GO);
    expect_stream("R9 disc idx2 last", DISC, 32'd3, 32'h0003_1E98);
    send3(DISC, 32'd3, 32'd7); wr(A_CTL, GO);
    expect_stream("R9 disc past end", DISC, 32'd3, 32'h0000_FFFF);
  endtask

  task automatic t_protocols;
    send3(P_A, 32'd3, 32'h1234_5678); wr(A_CTL, GO);
    expect_stream("R10 proto A", P_A, 32'd3, 32'hEDCB_A987);
    send3(32'hAB03_1E98, 32'd3, 32'h0000_FFFF); wr(A_CTL, GO);
    expect_stream("R6 proto B upper byte ignored", P_B, 32'd3, 32'hFFFF_0000);
  endtask

  task automatic t_unknown;
    send3(32'h0002_1234, 32'd3, 32'h0); wr(A_CTL, GO);
    expect_status("R6 unmatched sets error", ST_ERR);
    wr(A_CTL, ABORT);
    expect_status("R13 abort clears error", 32'h0);
  endtask

  task automatic t_short_then_reuse;
    wr(A_WMB, DISC); wr(A_WMB, 32'd3); wr(A_CTL, GO);
    expect_status("R5 two-dword GO errors, no ready", ST_ERR);
    send3(DISC, 32'd3, 32'd1); wr(A_CTL, GO);
    expect_status("R7 fresh object after failed GO", ST_RDY | ST_ERR);
    begin
      logic [31:0] v;
      rd(A_RMB, v); check("R7 reuse dw0", v, DISC);
    end
    wr(A_CTL, ABORT);
    expect_status("R13 abort mid-stream", 32'h0);
  endtask

  task automatic t_excess;
    send3(P_A, 32'd3, 32'h0000_0001); wr(A_WMB, 32'hDEAD_BEEF); wr(A_CTL, GO);
    expect_status("R4 extra dword dropped, GO ok", ST_RDY);
    expect_stream("R4 response unaffected", P_A, 32'd3, 32'hFFFF_FFFE);
    send3(P_A, 32'd2, 32'h0); wr(A_CTL, GO);
    expect_status("R4 length-2 stops at 2, GO error", ST_ERR);
    wr(A_CTL, ABORT);
  endtask

  task automatic t_len_field;
    send3(P_A, 32'hFFFC_0003, 32'h0); wr(A_CTL, GO);
    expect_status("R3 upper bits of length ignored", ST_RDY);
    wr(A_CTL, ABORT);
    send3(P_A, 32'h0000_0000, 32'h0); wr(A_CTL, GO);
    expect_status("R3 zero length is max, GO error", ST_ERR);
    wr(A_CTL, ABORT);
  endtask

  task automatic t_underflow;
    logic [31:0] v;
    rd(A_RMB, v); check("R12 empty read returns zero", v, 32'h0);
    expect_status("R12 empty read sets error", ST_ERR);
    wr(A_CTL, ABORT);
  endtask

  task automatic t_sizes;
    logic [31:0] v;
    send3(P_B, 32'd3, 32'h0F0F_0F0F); wr(A_CTL, GO);
    rd(A_RMB, v, 3'd2); check("R1 half read returns zero", v, 32'h0);
    wr(A_CTL, ABORT, 3'd1);
    expect_status("R1 byte abort ignored", ST_RDY);
    rd(A_RMB, v); check("R1 half read did not pop", v, P_B);
    wr(A_CTL, ABORT);
    wr(A_WMB, P_A); wr(A_WMB, 32'h5555_5555, 3'd2); wr(A_WMB, 32'd3); wr(A_WMB, 32'h0);
    wr(A_CTL, GO);
    expect_status("R1 half write ignored, object intact", ST_RDY);
    rd(A_STS, v, 3'd2); check("R1 half status read zero", v, 32'h0);
    wr(A_CTL, ABORT);
  endtask

  task automatic t_abort_go;
    send3(DISC, 32'd3, 32'd0); wr(A_CTL, GO | ABORT);
    expect_status("R13 abort wins over GO", 32'h0);
    wr(A_CTL, GO);
    expect_status("R13 count cleared by abort", ST_ERR);
    wr(A_CTL, ABORT);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_discovery();
    t_protocols();
    t_unknown();
    t_short_then_reuse();
    t_excess();
    t_len_field();
    t_underflow();
    t_sizes();
    t_abort_go();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule